// File: doc/BRIEF.md
# Parallel EEPROM Host Controller

This block sits between a synchronous system bus and a byte-wide parallel EEPROM. It turns single-byte read and write requests into sequences on the memory's active-low chip-enable, output-enable and write-enable strobes. It also drives the address bus and the direction of the data bus. Every analog interval is a count of system clock cycles. Each count is taken from a nanosecond parameter divided by the clock period and rounded up. The nanosecond parameters cover the access time, the write pulse, data setup and hold, bus turnaround, the self-timed internal write period and the lockout after power-up.

A requester raises `req` with `rdWr`, `addr` and `wdata` and holds them until it sees the one-cycle `ack`. It then waits for the one-cycle `done`. For a read, `rdata` holds the byte from the `done` cycle onward. The controller does not accept a request while busy. A request raised during that time waits and is accepted on the first idle cycle. The data bus is modelled as split lines: `eeDataOut` is what the controller would drive and `eeDataOe` enables it. The pad logic combines them with `eeDataIn`.

Top module: `eeprom_host_ctrl`

## Requirements
- R1: After reset the controller holds `busy` high and all three strobes high for INIT_CYC cycles. During that time it accepts no request, so a request raised at reset release is acknowledged INIT_CYC+1 cycles later.
- R2: A request sampled while idle is acknowledged by a one-cycle `ack` on the next cycle, with `busy` high. A request raised while busy is held and acknowledged the cycle after the controller returns to idle.
- R3: A read lowers chip-enable one cycle before output-enable. Output-enable then stays low for exactly RD_CYC cycles, and write-enable stays high. RD_CYC is the larger of the rounded address access time and the rounded output-enable access time.
- R4: The read byte is captured on the last output-enable-low cycle. `done` pulses RD_CYC+1 cycles after `ack`, and `rdata` then holds the byte stored at that address.
- R5: `eeDataOe` is never high while output-enable is low, and it is low in the cycle before output-enable falls.
- R6: A write holds chip-enable and write-enable low with output-enable high and the data bus driven, for WLO_CYC cycles. WLO_CYC is the larger of the rounded write pulse and the rounded data setup. The address and the data stay unchanged throughout.
- R7: After write-enable rises, chip-enable stays low and the data stays driven for WHI_CYC more cycles, the rounded data hold time.
- R8: After a write, chip-enable stays high for WC_CYC cycles, the rounded write cycle time. `done` and the return to idle come WLO_CYC+WHI_CYC+WC_CYC cycles after `ack`.
- R9: After a read, all strobes stay high and `busy` stays high for REC_CYC cycles (the rounded output turn-off time) following `done`.
- R10: Each cycle count is the ceiling of its nanosecond parameter over the clock period, and never less than one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until `ack` |
| rdWr | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Byte to write |
| ack | output | 1 | One-cycle pulse: request taken |
| busy | output | 1 | Controller cannot take a request |
| done | output | 1 | One-cycle pulse: access finished |
| rdata | output | DATA_W | Last byte read |
| eeCeN | output | 1 | Memory chip-enable, active low |
| eeOeN | output | 1 | Memory output-enable, active low |
| eeWeN | output | 1 | Memory write-enable, active low |
| eeAddr | output | ADDR_W | Memory address bus |
| eeDataOut | output | DATA_W | Data driven toward the memory |
| eeDataOe | output | 1 | Enable for `eeDataOut` onto the bus |
| eeDataIn | input | DATA_W | Data read back from the bus |

## Verification
Each result has a fixed due cycle, counted from the edge at which the request is sampled. `ack` is due one edge later. A read's `done` is due RD_CYC+1 edges after `ack`, and `busy` falls REC_CYC edges after that. A write's `done` and the fall of `busy` are both due WLO_CYC+WHI_CYC+WC_CYC edges after `ack`. The bench drives on falling edges and counts falling edges between events, so every latency is compared against an exact number of cycles. The bench's memory model returns a wrong byte unless output-enable has been low for the full access time. It also measures each strobe width and the chip-enable gap after a write, so both short and long timing are caught.

// File: rtl/eeprom_ctrl_pkg.sv
package eeprom_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_INIT, ST_IDLE, ST_RDPRE, ST_RD, ST_RDREC, ST_WRLO, ST_WRHI, ST_WRCYC
  } ctrl_state_e;

  typedef enum logic [2:0] {
    TM_INIT, TM_RD, TM_REC, TM_WLO, TM_WHI, TM_WCYC
  } tmr_sel_e;

  typedef struct packed {
    logic     takeReq;
    logic     capRead;
    logic     doneSet;
    logic     loadTmr;
    tmr_sel_e tmrSel;
    logic     driveBus;
    logic     ceN;
    logic     oeN;
    logic     weN;
  } dp_ctrl_t;

  function automatic int unsigned cycOf(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eeprom_ctrl_fsm.sv
module eeprom_ctrl_fsm
  import eeprom_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     req,
  input  logic     rdWr,
  input  logic     tmrZero,
  output dp_ctrl_t ctl,
  output logic     busy
);

  ctrl_state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_INIT;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    ctl.tmrSel  = TM_INIT;
    unique case (state)
      ST_INIT:  if (tmrZero) stateNext = ST_IDLE;
      ST_IDLE: begin
        if (req) begin
          ctl.takeReq = 1'b1;
          if (rdWr) begin
            stateNext = ST_RDPRE;
          end else begin
            stateNext   = ST_WRLO;
            ctl.loadTmr = 1'b1;
            ctl.tmrSel  = TM_WLO;
          end
        end
      end
      ST_RDPRE: begin
        stateNext   = ST_RD;
        ctl.loadTmr = 1'b1;
        ctl.tmrSel  = TM_RD;
      end
      ST_RD: begin
        if (tmrZero) begin
          stateNext   = ST_RDREC;
          ctl.capRead = 1'b1;
          ctl.doneSet = 1'b1;
          ctl.loadTmr = 1'b1;
          ctl.tmrSel  = TM_REC;
        end
      end
      ST_RDREC: if (tmrZero) stateNext = ST_IDLE;
      ST_WRLO: begin
        if (tmrZero) begin
          stateNext   = ST_WRHI;
          ctl.loadTmr = 1'b1;
          ctl.tmrSel  = TM_WHI;
        end
      end
      ST_WRHI: begin
        if (tmrZero) begin
          stateNext   = ST_WRCYC;
          ctl.loadTmr = 1'b1;
          ctl.tmrSel  = TM_WCYC;
        end
      end
      ST_WRCYC: begin
        if (tmrZero) begin
          stateNext   = ST_IDLE;
          ctl.doneSet = 1'b1;
        end
      end
      default: stateNext = ST_INIT;
    endcase

    // Strobes are decoded from the next state and registered in the datapath,
    // so the pins change exactly when the state does and never glitch.
    ctl.ceN      = !(stateNext inside {ST_RDPRE, ST_RD, ST_WRLO, ST_WRHI});
    ctl.oeN      = (stateNext != ST_RD);
    ctl.weN      = (stateNext != ST_WRLO);
    ctl.driveBus = (stateNext inside {ST_WRLO, ST_WRHI});
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/eeprom_ctrl_dp.sv
module eeprom_ctrl_dp
  import eeprom_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int TMR_W    = 8,
  parameter int INIT_CYC = 4,
  parameter int RD_CYC   = 2,
  parameter int REC_CYC  = 1,
  parameter int WLO_CYC  = 2,
  parameter int WHI_CYC  = 1,
  parameter int WC_CYC   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctrl_t          ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] eeDataIn,
  output logic              tmrZero,
  output logic              ack,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              eeCeN,
  output logic              eeOeN,
  output logic              eeWeN,
  output logic [ADDR_W-1:0] eeAddr,
  output logic [DATA_W-1:0] eeDataOut,
  output logic              eeDataOe
);

  logic [TMR_W-1:0] tmr, ldVal;

  always_comb begin
    unique case (ctl.tmrSel)
      TM_RD:   ldVal = TMR_W'(RD_CYC - 1);
      TM_REC:  ldVal = TMR_W'(REC_CYC - 1);
      TM_WLO:  ldVal = TMR_W'(WLO_CYC - 1);
      TM_WHI:  ldVal = TMR_W'(WHI_CYC - 1);
      TM_WCYC: ldVal = TMR_W'(WC_CYC - 1);
      default: ldVal = TMR_W'(INIT_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              tmr <= TMR_W'(INIT_CYC - 1);
    else if (ctl.loadTmr)   tmr <= ldVal;
    else if (tmr != '0)     tmr <= tmr - 1'b1;
  end

  assign tmrZero = (tmr == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eeAddr    <= '0;
      eeDataOut <= '0;
      rdata     <= '0;
    end else begin
      if (ctl.takeReq) begin
        eeAddr    <= addr;
        eeDataOut <= wdata;
      end
      if (ctl.capRead) rdata <= eeDataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eeCeN    <= 1'b1;
      eeOeN    <= 1'b1;
      eeWeN    <= 1'b1;
      eeDataOe <= 1'b0;
      ack      <= 1'b0;
      done     <= 1'b0;
    end else begin
      eeCeN    <= ctl.ceN;
      eeOeN    <= ctl.oeN;
      eeWeN    <= ctl.weN;
      eeDataOe <= ctl.driveBus;
      ack      <= ctl.takeReq;
      done     <= ctl.doneSet;
    end
  end

endmodule

// File: rtl/eeprom_host_ctrl.sv
module eeprom_host_ctrl
  import eeprom_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_ACC_NS      = 150,
  parameter int T_OE_NS       = 70,
  parameter int T_OFF_NS      = 50,
  parameter int T_WP_NS       = 100,
  parameter int T_DS_NS       = 50,
  parameter int T_DH_NS       = 10,
  parameter int T_WC_NS       = 5000000,
  parameter int T_INIT_NS     = 10000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              rdWr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              eeCeN,
  output logic              eeOeN,
  output logic              eeWeN,
  output logic [ADDR_W-1:0] eeAddr,
  output logic [DATA_W-1:0] eeDataOut,
  output logic              eeDataOe,
  input  logic [DATA_W-1:0] eeDataIn
);

  localparam int RD_CYC   = int'(maxOf(cycOf(T_ACC_NS, CLK_PERIOD_NS), cycOf(T_OE_NS, CLK_PERIOD_NS)));
  localparam int REC_CYC  = int'(cycOf(T_OFF_NS, CLK_PERIOD_NS));
  localparam int WLO_CYC  = int'(maxOf(cycOf(T_WP_NS, CLK_PERIOD_NS), cycOf(T_DS_NS, CLK_PERIOD_NS)));
  localparam int WHI_CYC  = int'(cycOf(T_DH_NS, CLK_PERIOD_NS));
  localparam int WC_CYC   = int'(cycOf(T_WC_NS, CLK_PERIOD_NS));
  localparam int INIT_CYC = int'(cycOf(T_INIT_NS, CLK_PERIOD_NS));
  localparam int MAX_CYC  = int'(maxOf(maxOf(maxOf(RD_CYC, REC_CYC), maxOf(WLO_CYC, WHI_CYC)),
                                       maxOf(WC_CYC, INIT_CYC)));
  localparam int TMR_W    = $clog2(MAX_CYC + 1);

  dp_ctrl_t ctl;
  logic     tmrZero;

  eeprom_ctrl_fsm i_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .req     (req),
    .rdWr    (rdWr),
    .tmrZero (tmrZero),
    .ctl     (ctl),
    .busy    (busy)
  );

  eeprom_ctrl_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TMR_W    (TMR_W),
    .INIT_CYC (INIT_CYC),
    .RD_CYC   (RD_CYC),
    .REC_CYC  (REC_CYC),
    .WLO_CYC  (WLO_CYC),
    .WHI_CYC  (WHI_CYC),
    .WC_CYC   (WC_CYC)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .addr      (addr),
    .wdata     (wdata),
    .eeDataIn  (eeDataIn),
    .tmrZero   (tmrZero),
    .ack       (ack),
    .done      (done),
    .rdata     (rdata),
    .eeCeN     (eeCeN),
    .eeOeN     (eeOeN),
    .eeWeN     (eeWeN),
    .eeAddr    (eeAddr),
    .eeDataOut (eeDataOut),
    .eeDataOe  (eeDataOe)
  );

endmodule

// File: rtl/eeprom_ctrl_chk.sv
module eeprom_ctrl_chk #(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int INIT_CYC = 4,
  parameter int RD_CYC   = 2,
  parameter int WLO_CYC  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              ack,
  input logic              busy,
  input logic              eeCeN,
  input logic              eeOeN,
  input logic              eeWeN,
  input logic [ADDR_W-1:0] eeAddr,
  input logic [DATA_W-1:0] eeDataOut,
  input logic              eeDataOe
);

  logic [31:0] sinceRst, oeRun, weRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceRst <= '0;
      oeRun    <= '0;
      weRun    <= '0;
    end else begin
      if (sinceRst != 32'hFFFF_FFFF) sinceRst <= sinceRst + 1;
      oeRun <= eeOeN ? '0 : oeRun + 1;
      weRun <= eeWeN ? '0 : weRun + 1;
    end
  end

  p_lockout_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < INIT_CYC) |-> (busy && eeCeN && eeWeN && eeOeN));

  p_ack_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> busy);

  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);

  p_ce_lead_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eeOeN) |-> (!$past(eeCeN) && eeWeN));

  p_oe_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeOeN) |-> (oeRun == RD_CYC));

  p_no_fight_r5: assert property (@(posedge clk) disable iff (!rstN)
    eeDataOe |-> eeOeN);

  p_turnaround_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eeOeN) |-> !$past(eeDataOe));

  p_we_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    !eeWeN |-> (!eeCeN && eeOeN && eeDataOe));

  p_we_width_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeWeN) |-> (weRun == WLO_CYC));

  p_wr_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!eeWeN && $past(!eeWeN)) |-> ($stable(eeDataOut) && $stable(eeAddr)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeWeN) |-> (!eeCeN && eeDataOe && $stable(eeDataOut)));

endmodule

bind eeprom_host_ctrl eeprom_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .INIT_CYC (INIT_CYC),
  .RD_CYC   (RD_CYC),
  .WLO_CYC  (WLO_CYC)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ack       (ack),
  .busy      (busy),
  .eeCeN     (eeCeN),
  .eeOeN     (eeOeN),
  .eeWeN     (eeWeN),
  .eeAddr    (eeAddr),
  .eeDataOut (eeDataOut),
  .eeDataOe  (eeDataOe)
);

// File: tb/test_eeprom_host_ctrl.sv
module test_eeprom_host_ctrl;

  localparam int PER   = 8;
  localparam int WC_NS = 400;
  localparam int IN_NS = 800;
  // Expected counts, worked out from the requirements (ceil of ns / period).
  localparam int E_RD   = (150 + PER - 1) / PER;        // 19
  localparam int E_REC  = (50 + PER - 1) / PER;         // 7
  localparam int E_WLO  = (100 + PER - 1) / PER;        // 13
  localparam int E_WHI  = (10 + PER - 1) / PER;         // 2
  localparam int E_WC   = (WC_NS + PER - 1) / PER;      // 50
  localparam int E_INIT = (IN_NS + PER - 1) / PER;      // 100

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic req = 1'b0;
  logic rdWr = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic ack, busy, done, eeCeN, eeOeN, eeWeN, eeDataOe;
  logic [7:0]  rdata, eeDataOut, eeDataIn;
  logic [14:0] eeAddr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  eeprom_host_ctrl #(
    .CLK_PERIOD_NS (PER),
    .T_WC_NS       (WC_NS),
    .T_INIT_NS     (IN_NS)
  ) i_eeprom_host_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .rdWr(rdWr), .addr(addr), .wdata(wdata),
    .ack(ack), .busy(busy), .done(done), .rdata(rdata),
    .eeCeN(eeCeN), .eeOeN(eeOeN), .eeWeN(eeWeN), .eeAddr(eeAddr),
    .eeDataOut(eeDataOut), .eeDataOe(eeDataOe), .eeDataIn(eeDataIn)
  );

  // Memory model: 64 bytes indexed by the low address bits.
  logic [7:0] mem [64];
  int oeRun, weRun, dhRun, ceHigh, lastOe, lastWe, lastDh, lastGap, viol, sinceRst;
  logic wrPending;

  initial for (int i = 0; i < 64; i++) mem[i] = 8'h00;

  always_comb begin
    if (!eeCeN && !eeOeN && (oeRun + 1) >= E_RD) eeDataIn = mem[eeAddr[5:0]];
    else eeDataIn = 8'hEE;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      oeRun <= 0; weRun <= 0; dhRun <= 0; ceHigh <= 0; lastOe <= 0; lastWe <= 0;
      lastDh <= 0; lastGap <= 0; viol <= 0; sinceRst <= 0; wrPending <= 1'b0;
    end else begin
      sinceRst <= sinceRst + 1;
      oeRun <= eeOeN ? 0 : oeRun + 1;
      if (eeOeN && oeRun != 0) lastOe <= oeRun;
      weRun <= eeWeN ? 0 : weRun + 1;
      if (eeWeN && weRun != 0) begin
        lastWe <= weRun;
        mem[eeAddr[5:0]] <= eeDataOut;
        wrPending <= 1'b1;
        if (!eeDataOe || eeCeN) viol <= viol + 1;
      end
      if (!eeCeN && eeWeN && eeDataOe) dhRun <= dhRun + 1;
      else if (dhRun != 0) begin lastDh <= dhRun; dhRun <= 0; end
      ceHigh <= eeCeN ? ceHigh + 1 : 0;
      if (!eeCeN && ceHigh != 0 && wrPending) begin
        lastGap <= ceHigh;
        wrPending <= 1'b0;
      end
      if (eeDataOe && !eeOeN) viol <= viol + 1;
      if (!eeWeN && sinceRst < E_INIT) viol <= viol + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic rw, input logic [14:0] a, input logic [7:0] d,
                      output int dLat, output int recLat, output logic [7:0] rd);
    @(negedge clk);
    req = 1'b1; rdWr = rw; addr = a; wdata = d;
    while (!ack) @(negedge clk);
    req = 1'b0;
    dLat = 0;
    while (!done) begin @(negedge clk); dLat++; end
    rd = rdata;
    recLat = 0;
    while (busy) begin @(negedge clk); recLat++; end
  endtask

  // {rdWr, addr, wdata, expected rdata}
  localparam logic [31:0] VEC [0:6] = '{
    {1'b0, 15'h0001, 8'hA5, 8'h00},
    {1'b0, 15'h7FC2, 8'h3C, 8'h00},
    {1'b1, 15'h0001, 8'h00, 8'hA5},
    {1'b1, 15'h7FC2, 8'h00, 8'h3C},
    {1'b0, 15'h0001, 8'h5A, 8'h00},
    {1'b1, 15'h0001, 8'h00, 8'h5A},
    {1'b1, 15'h0003, 8'h00, 8'h00}
  };

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    finishRun();
  end

  initial begin
    int cnt, dLat, recLat;
    logic [7:0] rd;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(busy && eeCeN && eeOeN && eeWeN && !eeDataOe && !ack && !done, "R1 reset state",
        {busy, eeCeN, eeOeN, eeWeN, eeDataOe, ack, done}, 7'b1111000);

    // R1: write raised at reset release waits out the lockout
    rstN = 1'b1;
    req = 1'b1; rdWr = 1'b0; addr = 15'h0010; wdata = 8'h77;
    cnt = 0;
    while (!ack) begin @(negedge clk); cnt++; end
    chk(cnt == E_INIT + 1, "R1 lockout ack latency", cnt, E_INIT + 1);
    req = 1'b0;
    dLat = 0;
    while (!done) begin @(negedge clk); dLat++; end
    chk(dLat == E_WLO + E_WHI + E_WC, "R8 write done latency", dLat, E_WLO + E_WHI + E_WC);
    chk(lastWe == E_WLO, "R6 WE low width", lastWe, E_WLO);
    chk(lastDh == E_WHI, "R7 data hold width", lastDh, E_WHI);
    chk(!busy, "R8 idle with done", busy, 0);

    // Vector table
    for (int v = 0; v < 7; v++) begin
      doOp(VEC[v][31], VEC[v][30:16], VEC[v][15:8], dLat, recLat, rd);
      if (VEC[v][31]) begin
        chk(dLat == E_RD + 1, "R4 read done latency", dLat, E_RD + 1);
        chk(rd == VEC[v][7:0], "R4 read data", rd, VEC[v][7:0]);
        chk(recLat == E_REC, "R9 read recovery", recLat, E_REC);
        chk(lastOe == E_RD, "R3 OE low width R10", lastOe, E_RD);
      end else begin
        chk(dLat == E_WLO + E_WHI + E_WC, "R8 write done latency", dLat, E_WLO + E_WHI + E_WC);
        chk(recLat == 0, "R8 busy ends with done", recLat, 0);
        chk(lastWe == E_WLO, "R6 WE low width R10", lastWe, E_WLO);
      end
    end

    // R2: read request raised while a write is busy is held until idle
    @(negedge clk);
    req = 1'b1; rdWr = 1'b0; addr = 15'h0025; wdata = 8'hC3;
    while (!ack) @(negedge clk);
    chk(busy, "R2 busy with ack", busy, 1);
    rdWr = 1'b1; addr = 15'h0025;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!ack);
    chk(cnt == E_WLO + E_WHI + E_WC + 1, "R2 held request latency", cnt, E_WLO + E_WHI + E_WC + 1);
    req = 1'b0;
    while (!done) @(negedge clk);
    chk(rdata == 8'hC3, "R2 held read data", rdata, 8'hC3);
    chk(lastGap >= E_WC, "R8 CE high after write", lastGap, E_WC);
    while (busy) @(negedge clk);
    chk(viol == 0, "R5 bus contention or lockout violations", viol, 0);
    finishRun();
  end

endmodule